// File: doc/BRIEF.md
# Two-Slot Fetch Group Former

This block is the front end of a fetch pipeline that pulls a group of sequential instructions out of one wide instruction-memory word each cycle. It owns the fetch program counter and presents it to the memory and to an external predictor. The memory returns one word holding every slot of the group, and the predictor returns a single taken flag, the slot it applies to, and a target. From these the block builds a per-slot valid mask, picks the address of the following group, and loads the result into an output register.

Only one prediction is used per group. A taken prediction ends the group at its slot and sends the next fetch to the target, so fetch never crosses a predicted-taken branch in the same cycle. The block never decodes the instruction in the predicted slot. A redirect from a later stage overrides everything and flushes the group.

The output is a valid/ready stream. One group moves when `out_valid`, `out_ready` and not `stall` are all true in the same cycle. While `out_valid` is high and `out_ready` is low, the output register and the fetch PC hold. `stall` freezes the fetch PC and the output register no matter what `out_ready` does, so no beat moves during a stall. A redirect is applied even during a stall or back-pressure.

Top module: `fetch_pair`

## Requirements
- R1: In reset, `fetch_pc` equals the `RESET_PC` parameter and `out_valid` is 0.
- R2: Slot i of a group is bits [32i+31:32i] of the word and sits at byte address base+4i. The base is `fetch_pc` with its low three bits cleared. With no taken prediction on a live slot, every slot from the start slot upward is valid and `out_next_pc` is base+8.
- R3: The start slot is `fetch_pc` bit 2. Slots below the start slot are invalid, so an unaligned PC gives mask 2'b10.
- R4: A taken prediction on slot p, with p at or above the start slot, clears the mask bits above p. `out_next_pc` and the next `fetch_pc` then equal `pred_target`.
- R5: A taken prediction on a slot below the start slot has no effect. The mask and next PC are the same as with no prediction.
- R6: The mask and next PC do not depend on the instruction bits. A prediction attached to a slot whose word is all zeros acts exactly like one attached to any other word.
- R7: A redirect sets `fetch_pc` to `redirect_pc` at the next edge and clears `out_valid` and `out_mask`. It wins over the prediction, `stall` and back-pressure.
- R8: While `stall` is high and there is no redirect, `fetch_pc` and all outputs keep their values.
- R9: While `out_valid` is high and `out_ready` is low (no redirect), `fetch_pc` and the output group hold. A group is accepted only when `out_valid`, `out_ready` and not `stall` are all true.
- R10: When a group is loaded, `out_group_pc` is the group base and `out_insn` is the fetched word. `fetch_pc` then advances to `out_next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes fetch PC and output register |
| redirect_valid | input | 1 | Later-stage redirect request |
| redirect_pc | input | AW | Redirect address |
| fetch_pc | output | AW | Address of the group being fetched |
| imem_word | input | SLOTS*IW | Instruction word at the group base |
| pred_taken | input | 1 | Predictor says taken |
| pred_slot | input | IDX_W | Slot the prediction is attached to |
| pred_target | input | AW | Predicted target |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Consumer accepts group |
| out_insn | output | SLOTS*IW | Group instructions, slot 0 lowest |
| out_mask | output | SLOTS | Per-slot valid bits |
| out_group_pc | output | AW | Base address of the output group |
| out_next_pc | output | AW | Address of the following group |

## Verification
The bench builds the block with the default two slots of 32 bits and a 32-bit address. It overrides the reset address to an unaligned value, 0x1004, so that the first group after reset already tests the upper-slot-only case. With one slot-select bit, random pairs of PC alignment and predicted slot cover every case: predictions below, at and above the start slot. Random stall, redirect and ready patterns make these cases overlap with holds and flushes.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;
  // Action the output stage takes at the next edge.
  typedef enum logic [1:0] {
    ACT_LOAD  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_FLUSH = 2'd2
  } fg_act_e;
endpackage

// File: rtl/fg_slot_mask.sv
`timescale 1ns/1ps
module fg_slot_mask #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic [IDX_W-1:0] start_slot,
  input  logic             pred_taken,
  input  logic [IDX_W-1:0] pred_slot,
  output logic             pred_eff,
  output logic [SLOTS-1:0] slot_mask
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);
  localparam logic [SLOTS-1:0] ALL_ONES  = {SLOTS{1'b1}};

  logic [SLOTS-1:0] from_start;
  logic [SLOTS-1:0] upto_pred;
  logic [IDX_W-1:0] cut_amt;

  // A prediction on a slot already skipped by the PC offset is dropped.
  assign pred_eff   = pred_taken && (pred_slot >= start_slot);
  assign from_start = ALL_ONES << start_slot;
  assign cut_amt    = LAST_SLOT - pred_slot;
  assign upto_pred  = pred_eff ? (ALL_ONES >> cut_amt) : ALL_ONES;

  for (genvar g = 0; g < SLOTS; g++) begin : g_bit
    assign slot_mask[g] = from_start[g] & upto_pred[g];
  end
endmodule

// File: rtl/fg_next_pc.sv
`timescale 1ns/1ps
module fg_next_pc #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SLOTS = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic [AW-1:0]    pc,
  input  logic             pred_eff,
  input  logic [AW-1:0]    pred_target,
  output logic [IDX_W-1:0] start_slot,
  output logic [AW-1:0]    group_base,
  output logic [AW-1:0]    next_pc
);
  localparam int unsigned   LOW_W  = IDX_W + 2;
  localparam logic [AW-1:0] STRIDE = AW'(SLOTS * 4);

  logic unused_byte_bits;
  assign unused_byte_bits = ^pc[1:0];

  assign start_slot = pc[2 +: IDX_W];
  assign group_base = {pc[AW-1:LOW_W], {LOW_W{1'b0}}};
  assign next_pc    = pred_eff ? pred_target : (group_base + STRIDE);
endmodule

// File: rtl/fg_ctrl.sv
`timescale 1ns/1ps
module fg_ctrl (
  input  logic            stall,
  input  logic            redirect_valid,
  input  logic            out_valid,
  input  logic            out_ready,
  output fg_pkg::fg_act_e act
);
  always_comb begin
    if (redirect_valid)                   act = fg_pkg::ACT_FLUSH;
    else if (stall)                       act = fg_pkg::ACT_HOLD;
    else if (out_valid && !out_ready)     act = fg_pkg::ACT_HOLD;
    else                                  act = fg_pkg::ACT_LOAD;
  end
endmodule

// File: rtl/fg_out_reg.sv
`timescale 1ns/1ps
module fg_out_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32,
  parameter int unsigned SLOTS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fg_pkg::fg_act_e     act,
  input  logic [SLOTS*IW-1:0] word,
  input  logic [SLOTS-1:0]    mask,
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       next_pc,
  output logic                valid_q,
  output logic [SLOTS*IW-1:0] insn_q,
  output logic [SLOTS-1:0]    mask_q,
  output logic [AW-1:0]       base_q,
  output logic [AW-1:0]       next_q
);
  logic [IW-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       slot_q[g] <= '0;
      else if (act == fg_pkg::ACT_LOAD) slot_q[g] <= word[g*IW +: IW];
    end
    assign insn_q[g*IW +: IW] = slot_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      base_q  <= '0;
      next_q  <= '0;
    end else begin
      case (act)
        fg_pkg::ACT_LOAD: begin
          valid_q <= 1'b1;
          mask_q  <= mask;
          base_q  <= base;
          next_q  <= next_pc;
        end
        fg_pkg::ACT_FLUSH: begin
          valid_q <= 1'b0;
          mask_q  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fetch_pair.sv
`timescale 1ns/1ps
module fetch_pair #(
  parameter int unsigned    SLOTS    = 2,
  parameter int unsigned    AW       = 32,
  parameter int unsigned    IW       = 32,
  parameter logic [AW-1:0]  RESET_PC = '0,
  localparam int unsigned   IDX_W    = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                redirect_valid,
  input  logic [AW-1:0]       redirect_pc,
  output logic [AW-1:0]       fetch_pc,
  input  logic [SLOTS*IW-1:0] imem_word,
  input  logic                pred_taken,
  input  logic [IDX_W-1:0]    pred_slot,
  input  logic [AW-1:0]       pred_target,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SLOTS*IW-1:0] out_insn,
  output logic [SLOTS-1:0]    out_mask,
  output logic [AW-1:0]       out_group_pc,
  output logic [AW-1:0]       out_next_pc
);
  logic [AW-1:0]    pc_q;
  logic [IDX_W-1:0] start_slot;
  logic [AW-1:0]    group_base;
  logic [AW-1:0]    next_pc;
  logic             pred_eff;
  logic [SLOTS-1:0] slot_mask;
  fg_pkg::fg_act_e  act;

  fg_next_pc #(.AW(AW), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_next (
    .pc          (pc_q),
    .pred_eff    (pred_eff),
    .pred_target (pred_target),
    .start_slot  (start_slot),
    .group_base  (group_base),
    .next_pc     (next_pc)
  );

  fg_slot_mask #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_mask (
    .start_slot (start_slot),
    .pred_taken (pred_taken),
    .pred_slot  (pred_slot),
    .pred_eff   (pred_eff),
    .slot_mask  (slot_mask)
  );

  fg_ctrl u_ctrl (
    .stall          (stall),
    .redirect_valid (redirect_valid),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .act            (act)
  );

  fg_out_reg #(.AW(AW), .IW(IW), .SLOTS(SLOTS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .word    (imem_word),
    .mask    (slot_mask),
    .base    (group_base),
    .next_pc (next_pc),
    .valid_q (out_valid),
    .insn_q  (out_insn),
    .mask_q  (out_mask),
    .base_q  (out_group_pc),
    .next_q  (out_next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else begin
      case (act)
        fg_pkg::ACT_FLUSH: pc_q <= redirect_pc;
        fg_pkg::ACT_LOAD:  pc_q <= next_pc;
        default: ;
      endcase
    end
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/fg_checker.sv
`timescale 1ns/1ps
module fg_checker #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned AW    = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             redirect_valid,
  input logic [AW-1:0]    redirect_pc,
  input logic [AW-1:0]    fetch_pc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SLOTS-1:0] out_mask,
  input logic [AW-1:0]    out_group_pc
);
  logic [SLOTS-1:0] low_bit;
  logic [SLOTS-1:0] run_cleared;
  assign low_bit     = out_mask & (~out_mask + SLOTS'(1));
  assign run_cleared = (out_mask + low_bit) & out_mask;

  assert_mask_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));

  assert_mask_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_cleared == '0));

  assert_redirect_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!out_valid && fetch_pc == $past(redirect_pc)));

  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect_valid) |=> ($stable(fetch_pc) && $stable(out_valid)
                                    && $stable(out_mask) && $stable(out_group_pc)));

  assert_backpressure_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect_valid) |=>
      (out_valid && $stable(out_mask) && $stable(out_group_pc) && $stable(fetch_pc)));

  assert_base_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_group_pc[IDX_W+1:0] == '0));
endmodule

bind fetch_pair fg_checker #(.SLOTS(SLOTS), .AW(AW)) u_fg_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stall          (stall),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .fetch_pc       (fetch_pc),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_mask       (out_mask),
  .out_group_pc   (out_group_pc)
);

// File: tb/fetch_pair_test.sv
`timescale 1ns/1ps
module fetch_pair_test;
  localparam logic [31:0] RST_PC = 32'h0000_1004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic [31:0] fetch_pc;
  logic [63:0] imem_word = '0;
  logic        pred_taken = 1'b0;
  logic [0:0]  pred_slot = '0;
  logic [31:0] pred_target = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_insn;
  logic [1:0]  out_mask;
  logic [31:0] out_group_pc;
  logic [31:0] out_next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fetch_pair #(.SLOTS(2), .AW(32), .IW(32), .RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fetch_pc(fetch_pc), .imem_word(imem_word),
    .pred_taken(pred_taken), .pred_slot(pred_slot), .pred_target(pred_target),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_mask(out_mask), .out_group_pc(out_group_pc), .out_next_pc(out_next_pc)
  );

  always #10 clk = ~clk;

  // Expected state built from the requirements.
  logic        m_valid = 1'b0;
  logic [31:0] m_pc = RST_PC;
  logic [1:0]  m_mask = '0;
  logic [63:0] m_insn = '0;
  logic [31:0] m_gpc = '0;
  logic [31:0] m_npc = '0;
  string       m_tag = "R1";

  function automatic logic [31:0] mem_at(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [63:0] word_at(logic [31:0] pc);
    logic [31:0] b = {pc[31:3], 3'b000};
    return {mem_at(b + 32'd4), mem_at(b)};
  endfunction

  function automatic logic eff_pred(logic [31:0] pc, logic pt, logic ps);
    return pt && (int'(ps) >= int'(pc[2]));
  endfunction

  function automatic logic [1:0] exp_mask(logic [31:0] pc, logic pt, logic ps);
    logic [1:0] m;
    for (int i = 0; i < 2; i++)
      m[i] = (i >= int'(pc[2])) && (!eff_pred(pc, pt, ps) || i <= int'(ps));
    return m;
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] pc, logic pt, logic ps, logic [31:0] tgt);
    return eff_pred(pc, pt, ps) ? tgt : ({pc[31:3], 3'b000} + 32'd8);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(fetch_pc == m_pc, m_tag, "fetch_pc", 64'(fetch_pc), 64'(m_pc));
    chk(out_valid == m_valid, m_tag, "out_valid", 64'(out_valid), 64'(m_valid));
    chk(out_mask == m_mask, m_tag, "out_mask", 64'(out_mask), 64'(m_mask));
    if (m_valid) begin
      chk(out_insn == m_insn, m_tag, "out_insn", out_insn, m_insn);
      chk(out_group_pc == m_gpc, m_tag, "out_group_pc", 64'(out_group_pc), 64'(m_gpc));
      chk(out_next_pc == m_npc, m_tag, "out_next_pc", 64'(out_next_pc), 64'(m_npc));
    end
  endtask

  // Called at a falling edge; drives inputs, runs one rising edge, checks at the next fall.
  task automatic step(bit st, bit rv, logic [31:0] rpc, bit pt, bit ps,
                      logic [31:0] tgt, bit rdy, bit zero_word);
    logic [31:0] n_pc = m_pc;
    logic        n_valid = m_valid;
    logic [1:0]  n_mask = m_mask;
    logic [63:0] n_insn = m_insn;
    logic [31:0] n_gpc = m_gpc;
    logic [31:0] n_npc = m_npc;
    string       n_tag;
    logic [63:0] w;
    w = zero_word ? 64'd0 : word_at(fetch_pc);
    stall = st; redirect_valid = rv; redirect_pc = rpc;
    pred_taken = pt; pred_slot = ps; pred_target = tgt;
    out_ready = rdy; imem_word = w;
    if (rv) begin
      n_tag = "R7"; n_pc = rpc; n_valid = 1'b0; n_mask = 2'b00;
    end else if (st) begin
      n_tag = "R8";
    end else if (m_valid && !rdy) begin
      n_tag = "R9";
    end else begin
      if (zero_word)                  n_tag = "R6";
      else if (eff_pred(m_pc, pt, ps)) n_tag = "R4";
      else if (pt)                    n_tag = "R5";
      else if (m_pc[2])               n_tag = "R3";
      else                            n_tag = "R2";
      n_valid = 1'b1;
      n_mask  = exp_mask(m_pc, pt, ps);
      n_insn  = w;
      n_gpc   = {m_pc[31:3], 3'b000};
      n_npc   = exp_next(m_pc, pt, ps, tgt);
      n_pc    = n_npc;
    end
    @(posedge clk);
    @(negedge clk);
    m_pc = n_pc; m_valid = n_valid; m_mask = n_mask; m_insn = n_insn;
    m_gpc = n_gpc; m_npc = n_npc; m_tag = n_tag;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    m_tag = "R1";
    chk(fetch_pc == RST_PC, "R1", "reset fetch_pc", 64'(fetch_pc), 64'(RST_PC));
    chk(out_valid == 1'b0, "R1", "reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    // R3: unaligned reset address, upper slot only
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk(out_mask == 2'b10, "R3", "unaligned mask", 64'(out_mask), 64'd2);
    // R2: sequential group, aligned
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk(out_next_pc == 32'h0000_1010, "R2", "seq next", 64'(out_next_pc), 64'h1010);
    // R7: redirect beats prediction and stall
    step(1, 1, 32'h0000_2000, 1, 0, 32'h0000_3000, 1, 0);
    // R4: taken at slot 0, aligned
    step(0, 0, 0, 1, 0, 32'h0000_4004, 1, 0);
    chk(out_mask == 2'b01, "R4", "cut after slot0", 64'(out_mask), 64'd1);
    // R5: at 0x4004, prediction on slot 0 is ignored
    step(0, 0, 0, 1, 0, 32'h0000_7777, 1, 0);
    chk(out_next_pc == 32'h0000_4008, "R5", "ignored pred next", 64'(out_next_pc), 64'h4008);
    // R6: prediction attached to an all-zero word
    step(0, 0, 0, 1, 0, 32'h0000_5000, 1, 1);
    chk(out_mask == 2'b01, "R6", "zero word mask", 64'(out_mask), 64'd1);
    // R8: stall holds
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 1, 1, 32'h0000_9000, 1, 0);
    // R9: back-pressure holds, then releases
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 32'h0000_6000, 1, 0);
    // R10 and all: random mix
    for (int n = 0; n < 4000; n++) begin
      bit st  = ($urandom % 8) == 0;
      bit rv  = ($urandom % 16) == 0;
      bit pt  = ($urandom % 3) == 0;
      bit ps  = 1'($urandom);
      bit rdy = ($urandom % 4) != 0;
      logic [31:0] rpc = $urandom & 32'h0000_FFFC;
      logic [31:0] tgt = $urandom & 32'h0000_FFFC;
      step(st, rv, rpc, pt, ps, tgt, rdy, ($urandom % 32) == 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule